// File: doc/BRIEF.md
# Timebase transfer target decoder

This block holds the destination for a transfer of the time-of-day value into one core's timebase, and it issues the transfer strobe to that core. Software first writes a 64-bit target control word. The word selects one of two addressing styles. In full-address style it carries a complete register address, and the block matches that address against a table of core base addresses. In core-ID style it carries a short core number. The block resolves the word to a core index and latches the index together with a valid flag.

A later move command is accepted only when four conditions hold together: the time-of-day controller is running, the command's arm bit is set, a valid target is latched, and the selected core reports that it is ready. An accepted move raises that core's bit in a one-hot sent vector for one cycle. A command that is refused raises a one-cycle error pulse instead and changes none of the latched state.

The core base table is built from a first base and a fixed stride: core i sits at `BASE0 + i*STRIDE`. The core count (at most 32) and the support for core-ID style are elaboration parameters.

Top module: `tbx_xfer_target`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `tgt_valid`, `tgt_core`, `sent` and `err_pulse` are all zero.
- R2: A control write with bit 28 set (bit 35 in MSB-first numbering) uses full-address style. The address is `cfg_wdata[63:32]`. If the low 12 bits of the address are not 12'h4A3, the next cycle shows `tgt_valid` low and `err_pulse` high.
- R3: In full-address style with a correct offset, address bits [31:12] are compared with bits [31:12] of each core base. A match latches that core (the lowest index wins) with `tgt_valid` high. No match latches `tgt_valid` low and pulses `err_pulse`.
- R4: A control write with bit 28 clear uses core-ID style. The core number is `cfg_wdata[36:32]`, and bit 37 is ignored. When CORE_ID_EN is 1 and the number is below NCORE, that core is latched as valid. Otherwise `tgt_valid` goes low and `err_pulse` pulses.
- R5: A move command (`mv_we`) while `tod_running` is low is refused.
- R6: A move command with `mv_wdata[63]` clear (bit 0 in MSB-first numbering) is refused.
- R7: A move command while `tgt_valid` is low is refused.
- R8: A move command while `core_ready[tgt_core]` is low is refused.
- R9: An accepted move drives `sent` to the one-hot value for `tgt_core` during exactly the one cycle after the command. `err_pulse` stays low unless a bad control write falls in the same cycle. `sent` is zero in every other cycle.
- R10: A refused move pulses `err_pulse` for one cycle, leaves `sent` at zero, and leaves `tgt_valid` and `tgt_core` unchanged.
- R11: When a control write and a move occur in the same cycle, the move is judged against the target latched before that cycle, and the new target takes effect afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Target control word write strobe |
| cfg_wdata | input | 64 | Target control word |
| mv_we | input | 1 | Move command strobe |
| mv_wdata | input | 64 | Move command value; bit 63 arms the move |
| tod_running | input | 1 | Time-of-day controller is in its running state |
| core_ready | input | NCORE | Per-core ready-for-transfer flags |
| tgt_valid | output | 1 | A resolved target is latched |
| tgt_core | output | IDXW | Latched target core index |
| sent | output | NCORE | One-cycle one-hot transfer strobe per core |
| err_pulse | output | 1 | One-cycle pulse for a refused command or an unresolvable target |

## Verification
The bench probes the offset check with an address that matches a base but carries the wrong offset. A decoder that skipped this check would report a valid target. The bench checks that a core number with bit 37 set lands on the low five bits. A decoder that kept six bits would reject the write or pick the wrong core. Each of the four move conditions is failed on its own while the other three hold, so that any dropped condition shows up as a spurious `sent` bit. The bench also writes a new target in the same cycle as a move. A design that forwarded the new target into the move would strobe the wrong core.

// File: rtl/tbx_pkg.sv
package tbx_pkg;

  localparam int unsigned ADDR_W     = 32;
  localparam logic [11:0] XFER_OFS   = 12'h4A3;
  localparam int unsigned MODE_BIT   = 28;
  localparam int unsigned ARM_BIT    = 63;

  typedef enum logic {
    MODE_COREID = 1'b0,
    MODE_FULL   = 1'b1
  } tgt_mode_e;

  function automatic tgt_mode_e get_mode(input logic [63:0] d);
    return d[MODE_BIT] ? MODE_FULL : MODE_COREID;
  endfunction

  function automatic logic [ADDR_W-1:0] get_addr(input logic [63:0] d);
    return d[63:32];
  endfunction

  function automatic logic [4:0] get_core_id(input logic [63:0] d);
    return d[36:32];
  endfunction

  function automatic logic move_armed(input logic [63:0] d);
    return d[ARM_BIT];
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [ADDR_W-1:0] b0,
                                                input logic [ADDR_W-1:0] stride,
                                                input int unsigned idx);
    return b0 + stride * idx;
  endfunction

  function automatic logic page_eq(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:12] == b[ADDR_W-1:12];
  endfunction

endpackage

// File: rtl/tbx_dec.sv
module tbx_dec import tbx_pkg::*; #(
  parameter int unsigned NCORE      = 4,
  parameter int unsigned IDXW       = 2,
  parameter bit          CORE_ID_EN = 1'b1,
  parameter logic [31:0] BASE0      = 32'h2000_0000,
  parameter logic [31:0] STRIDE     = 32'h0100_0000
) (
  input  logic [63:0]     wdata,
  output logic            dec_ok,
  output logic [IDXW-1:0] dec_idx
);

  logic [ADDR_W-1:0] addr;
  logic [NCORE-1:0]  hit;
  logic              full_ok;
  logic [IDXW-1:0]   full_idx;
  logic              id_ok;
  logic [4:0]        id;

  assign addr = get_addr(wdata);
  assign id   = get_core_id(wdata);

  for (genvar i = 0; i < NCORE; i++) begin : g_cmp
    assign hit[i] = page_eq(addr, base_of(BASE0, STRIDE, i));
  end

  always_comb begin
    full_idx = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (hit[i]) full_idx = IDXW'(i);
    end
  end

  assign full_ok = (addr[11:0] == XFER_OFS) && (|hit);

  if (CORE_ID_EN) begin : g_id_on
    assign id_ok = ({1'b0, id} < 6'(NCORE));
  end else begin : g_id_off
    assign id_ok = 1'b0;
  end

  always_comb begin
    if (get_mode(wdata) == MODE_FULL) begin
      dec_ok  = full_ok;
      dec_idx = full_idx;
    end else begin
      dec_ok  = id_ok;
      dec_idx = IDXW'(id);
    end
  end

endmodule

// File: rtl/tbx_tgt.sv
module tbx_tgt #(
  parameter int unsigned IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            ok_in,
  input  logic [IDXW-1:0] idx_in,
  output logic            valid_q,
  output logic [IDXW-1:0] idx_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (load) begin
      valid_q <= ok_in;
      if (ok_in) idx_q <= idx_in;
    end
  end

endmodule

// File: rtl/tbx_gate.sv
module tbx_gate import tbx_pkg::*; #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned IDXW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mv_we,
  input  logic [63:0]      mv_wdata,
  input  logic             running,
  input  logic             tgt_ok,
  input  logic [IDXW-1:0]  tgt_idx,
  input  logic [NCORE-1:0] ready,
  input  logic             cfg_bad,
  output logic             accept,
  output logic [NCORE-1:0] sent_q,
  output logic             err_q
);

  logic sel_ready;
  logic reject;

  assign sel_ready = ready[tgt_idx];
  assign accept    = mv_we && running && move_armed(mv_wdata) && tgt_ok && sel_ready;
  assign reject    = mv_we && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      err_q  <= 1'b0;
    end else begin
      sent_q <= accept ? (NCORE'(1) << tgt_idx) : '0;
      err_q  <= reject || cfg_bad;
    end
  end

endmodule

// File: rtl/tbx_xfer_target.sv
module tbx_xfer_target #(
  parameter int unsigned NCORE      = 4,
  parameter bit          CORE_ID_EN = 1'b1,
  parameter logic [31:0] BASE0      = 32'h2000_0000,
  parameter logic [31:0] STRIDE     = 32'h0100_0000,
  localparam int unsigned IDXW      = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [63:0]      cfg_wdata,
  input  logic             mv_we,
  input  logic [63:0]      mv_wdata,
  input  logic             tod_running,
  input  logic [NCORE-1:0] core_ready,
  output logic             tgt_valid,
  output logic [IDXW-1:0]  tgt_core,
  output logic [NCORE-1:0] sent,
  output logic             err_pulse
);

  logic            dec_ok;
  logic [IDXW-1:0] dec_idx;
  logic            cfg_bad;
  logic            mv_accept;

  assign cfg_bad = cfg_we && !dec_ok;

  tbx_dec #(
    .NCORE(NCORE), .IDXW(IDXW), .CORE_ID_EN(CORE_ID_EN),
    .BASE0(BASE0), .STRIDE(STRIDE)
  ) u_dec (
    .wdata   (cfg_wdata),
    .dec_ok  (dec_ok),
    .dec_idx (dec_idx)
  );

  tbx_tgt #(.IDXW(IDXW)) u_tgt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_we),
    .ok_in   (dec_ok),
    .idx_in  (dec_idx),
    .valid_q (tgt_valid),
    .idx_q   (tgt_core)
  );

  tbx_gate #(.NCORE(NCORE), .IDXW(IDXW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv_we    (mv_we),
    .mv_wdata (mv_wdata),
    .running  (tod_running),
    .tgt_ok   (tgt_valid),
    .tgt_idx  (tgt_core),
    .ready    (core_ready),
    .cfg_bad  (cfg_bad),
    .accept   (mv_accept),
    .sent_q   (sent),
    .err_q    (err_pulse)
  );

endmodule

// File: rtl/tbx_xfer_target_chk.sv
module tbx_xfer_target_chk #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned IDXW  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [63:0]      cfg_wdata,
  input logic             mv_we,
  input logic [63:0]      mv_wdata,
  input logic             tod_running,
  input logic [NCORE-1:0] core_ready,
  input logic             tgt_valid,
  input logic [IDXW-1:0]  tgt_core,
  input logic [NCORE-1:0] sent,
  input logic             err_pulse,
  input logic             mv_accept
);

  // R9
  sent_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sent));

  // R9
  sent_needs_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_we |=> (sent == '0));

  // R5
  sent_needs_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sent != '0) |-> $past(tod_running && mv_wdata[63] && tgt_valid));

  // R8
  sent_right_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sent != '0) |-> (sent[$past(tgt_core)] && $past(core_ready[tgt_core])));

  // R10
  reject_holds_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_we && !mv_accept && !cfg_we) |=> (err_pulse && $stable(tgt_valid) && $stable(tgt_core)));

  // R2
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[28] && (cfg_wdata[43:32] != 12'h4A3)) |=> (!tgt_valid && err_pulse));

endmodule

bind tbx_xfer_target tbx_xfer_target_chk #(.NCORE(NCORE), .IDXW(IDXW)) u_chk (.*);

// File: tb/tb_tbx_xfer_target.sv
module tb_tbx_xfer_target;

  localparam int CLK_PERIOD = 10;
  localparam int NC         = 4;
  localparam int IW         = 2;
  localparam logic [31:0] B0 = 32'h2000_0000;
  localparam logic [31:0] ST = 32'h0100_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [63:0]   cfg_wdata = '0;
  logic          mv_we = 1'b0;
  logic [63:0]   mv_wdata = '0;
  logic          tod_running = 1'b0;
  logic [NC-1:0] core_ready = '0;
  logic          tgt_valid;
  logic [IW-1:0] tgt_core;
  logic [NC-1:0] sent;
  logic          err_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  bit     m_valid = 0;
  int     m_idx = 0;
  int     m_sent = 0;
  bit     m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbx_xfer_target #(.NCORE(NC), .CORE_ID_EN(1'b1), .BASE0(B0), .STRIDE(ST)) dut (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .mv_we, .mv_wdata, .tod_running,
    .core_ready, .tgt_valid, .tgt_core, .sent, .err_pulse
  );

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_idx = 0; m_sent = 0; m_err = 0;
    end else begin
      bit acc;
      acc = mv_we && tod_running && mv_wdata[63] && m_valid && core_ready[m_idx];
      m_sent = acc ? (1 << m_idx) : 0;
      m_err  = mv_we && !acc;
      if (cfg_we) begin
        bit ok;
        int pick;
        ok = 0; pick = 0;
        if (cfg_wdata[28]) begin
          logic [31:0] a;
          a = cfg_wdata[63:32];
          if (a[11:0] == 12'h4A3) begin
            for (int k = NC - 1; k >= 0; k--) begin
              logic [31:0] b;
              b = B0 + ST * k;
              if (a[31:12] == b[31:12]) begin ok = 1; pick = k; end
            end
          end
        end else begin
          pick = int'(cfg_wdata[36:32]);
          ok = (pick < NC);
        end
        m_valid = ok;
        if (ok) m_idx = pick;
        if (!ok) m_err = 1;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    cmp("tgt_valid", int'(tgt_valid), int'(m_valid));
    cmp("tgt_core", int'(tgt_core), m_idx);
    cmp("sent", int'(sent), m_sent);
    cmp("err_pulse", int'(err_pulse), int'(m_err));
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [63:0] full_w(input logic [31:0] a);
    return {a, 32'h0} | (64'h1 << 28);
  endfunction

  function automatic logic [63:0] id_w(input logic [5:0] id);
    return {26'h0, id, 32'h0};
  endfunction

  localparam logic [63:0] ARM = 64'h8000_0000_0000_0000;

  task automatic step(input bit cw, input logic [63:0] cd, input bit mw, input logic [63:0] md);
    @(posedge clk); #1;
    cfg_we = cw; cfg_wdata = cd; mv_we = mw; mv_wdata = md;
    @(posedge clk); #1;
    cfg_we = 0; mv_we = 0;
  endtask

  // explicit hand-computed check, sampled at the following falling edge
  task automatic expect_out(string t, bit v, int idx, int s, bit e);
    @(negedge clk); #1;
    tag = t;
    cmp("hand tgt_valid", int'(tgt_valid), int'(v));
    if (v) cmp("hand tgt_core", int'(tgt_core), idx);
    cmp("hand sent", int'(sent), s);
    cmp("hand err", int'(err_pulse), int'(e));
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_out("R1", 0, 0, 0, 0);
    tod_running = 1; core_ready = 4'b1111;

    tag = "R4"; step(1, id_w(6'd2), 0, '0);
    expect_out("R4", 1, 2, 0, 0);
    tag = "R9"; step(0, '0, 1, ARM);
    expect_out("R9", 1, 2, 4'b0100, 0);
    tag = "R5"; tod_running = 0; step(0, '0, 1, ARM);
    expect_out("R5", 1, 2, 0, 1);
    tod_running = 1;
    tag = "R6"; step(0, '0, 1, 64'h1);
    expect_out("R6", 1, 2, 0, 1);
    tag = "R8"; core_ready = 4'b1011; step(0, '0, 1, ARM);
    expect_out("R8", 1, 2, 0, 1);
    core_ready = 4'b1111;
    tag = "R10"; step(0, '0, 0, '0);
    expect_out("R10", 1, 2, 0, 0);

    tag = "R2"; step(1, full_w(32'h2100_04A4), 0, '0);
    expect_out("R2", 0, 0, 0, 1);
    tag = "R7"; step(0, '0, 1, ARM);
    expect_out("R7", 0, 0, 0, 1);
    tag = "R3"; step(1, full_w(32'h2300_04A3), 0, '0);
    expect_out("R3", 1, 3, 0, 0);
    step(0, '0, 1, ARM);
    expect_out("R3", 1, 3, 4'b1000, 0);
    step(1, full_w(32'h7000_04A3), 0, '0);
    expect_out("R3", 0, 0, 0, 1);

    tag = "R4"; step(1, id_w(6'd5), 0, '0);
    expect_out("R4", 0, 0, 0, 1);
    step(1, id_w(6'b100001), 0, '0);
    expect_out("R4", 1, 1, 0, 0);

    tag = "R11"; step(1, id_w(6'd0), 1, ARM);
    expect_out("R11", 1, 0, 4'b0010, 0);
    step(0, '0, 1, ARM);
    expect_out("R11", 1, 0, 4'b0001, 0);

    tag = "R9"; step(0, '0, 0, '0);
    expect_out("R9", 1, 0, 0, 0);

    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    finish_run();
  end

endmodule